// File: doc/BRIEF.md
# Accumulator ALU with Status Word

This block is the arithmetic heart of a small accumulator machine. It holds an accumulator, an auxiliary B register and a status word. Each clock it applies one operation chosen by a 4-bit select, using an operand bus, the accumulator and (for multiply and divide) the B register. Results land in the accumulator and, for multiply and divide, in B. The status word keeps carry, auxiliary (half) carry and signed overflow in registers. Its parity bit is derived at all times from the accumulator. The register-select and spare software bits are held at their reset value, because no write path exists here.

There is no negative or zero flag. A separate output reports an all-zero accumulator, and the accumulator's top bit serves as the sign. Instruction decode and memory access stay outside the block. A sequencer drives one select per cycle, and the results can be seen one clock later.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator, B and the whole 8-bit status word are 0, and the zero output is 1.
- R2: Select 5 (add) sets A to (A + operand) mod 256. Select 6 (add with carry) also adds the carry bit. Carry, at status bit 7, becomes the carry out of bit 7.
- R3: For selects 5, 6 and 7, the auxiliary carry at status bit 6 becomes the carry (add) or borrow (subtract) between the low and high nibble.
- R4: For selects 5, 6 and 7, overflow at status bit 2 becomes 1 exactly when the two's complement result does not fit in 8 bits.
- R5: Select 7 (subtract with borrow) sets A to (A - operand - carry) mod 256, and carry becomes 1 when a borrow into bit 7 occurs.
- R6: Selects 8 (and), 9 (or), 10 (xor with operand), 11 (invert A), 12 (increment A) and 13 (decrement A, wrapping) update only A. Carry, auxiliary carry and overflow remain unchanged.
- R7: Select 14 (multiply A by B) puts the low product byte in A and the high byte in B. It clears carry, and sets overflow exactly when the product exceeds 255.
- R8: Select 15 (divide A by B) puts the quotient in A and the remainder in B, clears carry and clears overflow. With B equal to 0 it sets overflow, clears carry and leaves A and B unchanged.
- R9: Status bit 0 always equals the XOR of all accumulator bits.
- R10: Status bits 1, 3, 4 and 5 stay 0 under every select.
- R11: The zero output is 1 exactly when the accumulator holds 0.
- R12: Select 0 changes nothing. Select 1 loads A from the operand, select 2 loads B from the operand, select 3 clears carry and select 4 sets carry. None of them touches any other state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 4 | Operation select for this cycle |
| operand | input | 8 | Second operand / load value |
| acc_q | output | 8 | Accumulator |
| breg_q | output | 8 | B register |
| psw_q | output | 8 | Status word |
| acc_is_zero | output | 1 | High when the accumulator is 0 |

## Verification
Every one of the 256 accumulator values is combined with the operands 0x00, 0x01, 0x0F, 0x7F, 0x80 and 0xFF, once with carry clear and once with carry set. Together these hit nibble-boundary half carries, signed overflow on both sides of 0x7F/0x80, and full carry and borrow wrap. The same set covers a zero divisor, a one divisor, and products above and below 255, which separates the stable divide-by-zero path from normal division. Running the logic, increment and decrement selects with carry both set and clear shows that they leave the arithmetic flags alone.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   typedef enum logic [3:0] {
      OP_NOP  = 4'h0, OP_LDA  = 4'h1, OP_LDB  = 4'h2, OP_CLRC = 4'h3,
      OP_SETC = 4'h4, OP_ADD  = 4'h5, OP_ADDC = 4'h6, OP_SUBB = 4'h7,
      OP_AND  = 4'h8, OP_OR   = 4'h9, OP_XOR  = 4'hA, OP_CPL  = 4'hB,
      OP_INC  = 4'hC, OP_DEC  = 4'hD, OP_MUL  = 4'hE, OP_DIV  = 4'hF
   } alu_op_e;

   localparam int PSW_W  = 8;
   localparam int PSW_P  = 0;
   localparam int PSW_OV = 2;
   localparam int PSW_AC = 6;
   localparam int PSW_CY = 7;

   typedef struct packed {
      logic cy;
      logic ac;
      logic ov;
   } arith_flags_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] res_o,
   output arith_flags_t     flg_o
);
   localparam int HALF = WIDTH / 2;

   logic [WIDTH:0] full;
   logic [HALF:0]  low;
   logic           sign_a, sign_b, sign_r;

   always_comb begin
      if (sub_i) begin
         full = {1'b0, a_i} - {1'b0, b_i} - {{WIDTH{1'b0}}, cin_i};
         low  = {1'b0, a_i[HALF-1:0]} - {1'b0, b_i[HALF-1:0]} - {{HALF{1'b0}}, cin_i};
      end else begin
         full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
         low  = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
      end
   end

   assign sign_a   = a_i[WIDTH-1];
   assign sign_b   = b_i[WIDTH-1];
   assign sign_r   = full[WIDTH-1];
   assign res_o    = full[WIDTH-1:0];
   assign flg_o.cy = full[WIDTH];
   assign flg_o.ac = low[HALF];
   // add: like signs in, other sign out; subtract: unlike signs in, sign flips
   assign flg_o.ov = sub_i ? ((sign_a != sign_b) && (sign_r != sign_a))
                           : ((sign_a == sign_b) && (sign_r != sign_a));
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] prod_lo_o,
   output logic [WIDTH-1:0] prod_hi_o,
   output logic             prod_wide_o,
   output logic [WIDTH-1:0] quot_o,
   output logic [WIDTH-1:0] rem_o,
   output logic             div_zero_o
);
   localparam int PW = 2 * WIDTH;

   logic [PW-1:0] prod;

   assign prod        = {{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i};
   assign prod_lo_o   = prod[WIDTH-1:0];
   assign prod_hi_o   = prod[PW-1:WIDTH];
   assign prod_wide_o = |prod[PW-1:WIDTH];
   assign div_zero_o  = (b_i == '0);
   assign quot_o      = div_zero_o ? '0 : a_i / b_i;
   assign rem_o       = div_zero_o ? '0 : a_i % b_i;
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] res_o
);
   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   always_comb begin
      unique case (op_i)
         OP_LDA:  res_o = b_i;
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_CPL:  res_o = ~a_i;
         OP_INC:  res_o = a_i + ONE;
         OP_DEC:  res_o = a_i - ONE;
         default: res_o = a_i;
      endcase
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       op_sel,
   input  logic [WIDTH-1:0] operand,
   output logic [WIDTH-1:0] acc_q,
   output logic [WIDTH-1:0] breg_q,
   output logic [PSW_W-1:0] psw_q,
   output logic             acc_is_zero
);
   localparam int HELD_W = 4;

   if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
      $error("acc_alu: WIDTH must be even and at least 4");
   end

   alu_op_e          op;
   logic [WIDTH-1:0] as_res, lg_res, m_lo, m_hi, d_quo, d_rem;
   logic             m_wide, d_zero, as_cin, as_sub;
   arith_flags_t     as_flg;
   logic             cy_q, ac_q, ov_q;
   logic [HELD_W-1:0] held_q;

   assign op     = alu_op_e'(op_sel);
   assign as_sub = (op == OP_SUBB);
   assign as_cin = ((op == OP_ADDC) || (op == OP_SUBB)) ? cy_q : 1'b0;

   acc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a_i(acc_q), .b_i(operand), .cin_i(as_cin), .sub_i(as_sub),
      .res_o(as_res), .flg_o(as_flg)
   );

   acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .op_i(op), .a_i(acc_q), .b_i(operand), .res_o(lg_res)
   );

   acc_alu_muldiv #(.WIDTH(WIDTH)) u_muldiv (
      .a_i(acc_q), .b_i(breg_q),
      .prod_lo_o(m_lo), .prod_hi_o(m_hi), .prod_wide_o(m_wide),
      .quot_o(d_quo), .rem_o(d_rem), .div_zero_o(d_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         breg_q <= '0;
         cy_q   <= 1'b0;
         ac_q   <= 1'b0;
         ov_q   <= 1'b0;
         held_q <= '0;
      end else begin
         unique case (op)
            OP_NOP: ;
            OP_LDB:  breg_q <= operand;
            OP_CLRC: cy_q   <= 1'b0;
            OP_SETC: cy_q   <= 1'b1;
            OP_ADD, OP_ADDC, OP_SUBB: begin
               acc_q <= as_res;
               cy_q  <= as_flg.cy;
               ac_q  <= as_flg.ac;
               ov_q  <= as_flg.ov;
            end
            OP_MUL: begin
               acc_q  <= m_lo;
               breg_q <= m_hi;
               cy_q   <= 1'b0;
               ov_q   <= m_wide;
            end
            OP_DIV: begin
               cy_q <= 1'b0;
               ov_q <= d_zero;
               if (!d_zero) begin
                  acc_q  <= d_quo;
                  breg_q <= d_rem;
               end
            end
            default: acc_q <= lg_res;
         endcase
      end
   end

   assign psw_q = {cy_q, ac_q, held_q[3], held_q[2], held_q[1], ov_q, held_q[0], ^acc_q};
   assign acc_is_zero = (acc_q == '0);
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       op_sel,
   input logic [WIDTH-1:0] operand,
   input logic [WIDTH-1:0] acc_q,
   input logic [WIDTH-1:0] breg_q,
   input logic [PSW_W-1:0] psw_q,
   input logic             acc_is_zero
);
   a_r7_mul_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_MUL) |=> !psw_q[PSW_CY]);

   a_r8_div_zero_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_DIV && breg_q == '0) |=> psw_q[PSW_OV] && $stable(acc_q) && $stable(breg_q));

   a_r6_logic_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel >= OP_AND && op_sel <= OP_DEC)
      |=> $stable(psw_q[PSW_CY]) && $stable(psw_q[PSW_AC]) && $stable(psw_q[PSW_OV]));

   a_r12_nop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_NOP) |=> $stable(acc_q) && $stable(breg_q) && $stable(psw_q));

   a_r12_setc: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_SETC) |=> psw_q[PSW_CY]);

   a_r11_zero_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_LDA && operand == '0) |=> acc_is_zero);
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .operand(operand),
   .acc_q(acc_q), .breg_q(breg_q), .psw_q(psw_q), .acc_is_zero(acc_is_zero)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
   import acc_alu_pkg::*;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   op_sel = 4'h0;
   logic [W-1:0] operand = '0;
   logic [W-1:0] acc_q, breg_q;
   logic [7:0]   psw_q;
   logic         acc_is_zero;

   int checks = 0;
   int fails  = 0;
   int m_a = 0, m_b = 0;
   int m_cy = 0, m_ac = 0, m_ov = 0;

   always #10 clk = ~clk;

   acc_alu #(.WIDTH(W)) i_acc_alu (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .operand(operand),
      .acc_q(acc_q), .breg_q(breg_q), .psw_q(psw_q), .acc_is_zero(acc_is_zero)
   );

   task automatic chk(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   function automatic int sx(int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   function automatic string tag_of(alu_op_e c);
      case (c)
         OP_ADD, OP_ADDC: return "R2";
         OP_SUBB:         return "R5";
         OP_MUL:          return "R7";
         OP_DIV:          return "R8";
         OP_AND, OP_OR, OP_XOR, OP_CPL, OP_INC, OP_DEC: return "R6";
         default:         return "R12";
      endcase
   endfunction

   task automatic model(alu_op_e c, int v);
      int cin, s, sr;
      case (c)
         OP_LDA:  m_a = v;
         OP_LDB:  m_b = v;
         OP_CLRC: m_cy = 0;
         OP_SETC: m_cy = 1;
         OP_ADD, OP_ADDC: begin
            cin  = (c == OP_ADDC) ? m_cy : 0;
            s    = m_a + v + cin;
            sr   = sx(m_a) + sx(v) + cin;
            m_ac = (((m_a & 15) + (v & 15) + cin) > 15) ? 1 : 0;
            m_ov = (sr > 127 || sr < -128) ? 1 : 0;
            m_cy = (s > 255) ? 1 : 0;
            m_a  = s & 255;
         end
         OP_SUBB: begin
            cin  = m_cy;
            s    = m_a - v - cin;
            sr   = sx(m_a) - sx(v) - cin;
            m_ac = (((m_a & 15) - (v & 15) - cin) < 0) ? 1 : 0;
            m_ov = (sr > 127 || sr < -128) ? 1 : 0;
            m_cy = (s < 0) ? 1 : 0;
            m_a  = s & 255;
         end
         OP_AND: m_a = m_a & v;
         OP_OR:  m_a = m_a | v;
         OP_XOR: m_a = m_a ^ v;
         OP_CPL: m_a = (~m_a) & 255;
         OP_INC: m_a = (m_a + 1) & 255;
         OP_DEC: m_a = (m_a + 255) & 255;
         OP_MUL: begin
            s    = m_a * m_b;
            m_a  = s & 255;
            m_b  = s >> 8;
            m_cy = 0;
            m_ov = (s > 255) ? 1 : 0;
         end
         OP_DIV: begin
            m_cy = 0;
            if (m_b == 0) m_ov = 1;
            else begin
               m_ov = 0;
               s    = m_a / m_b;
               m_b  = m_a % m_b;
               m_a  = s;
            end
         end
         default: ;
      endcase
   endtask

   task automatic verify(alu_op_e c);
      string t;
      bit    arith;
      t     = tag_of(c);
      arith = (c == OP_ADD || c == OP_ADDC || c == OP_SUBB);
      chk({t, " acc"}, int'(acc_q), m_a);
      chk({t, " breg"}, int'(breg_q), m_b);
      chk({t, " carry"}, int'(psw_q[7]), m_cy);
      chk(arith ? "R3 aux carry" : {t, " aux carry"}, int'(psw_q[6]), m_ac);
      chk(arith ? "R4 overflow" : {t, " overflow"}, int'(psw_q[2]), m_ov);
      chk("R9 parity", int'(psw_q[0]), $countones(m_a) & 1);
      chk("R10 held bits", int'({psw_q[5], psw_q[4], psw_q[3], psw_q[1]}), 0);
      chk("R11 zero", int'(acc_is_zero), (m_a == 0) ? 1 : 0);
   endtask

   task automatic step(alu_op_e c, int v);
      op_sel  = c;
      operand = v[W-1:0];
      @(negedge clk);
      op_sel  = OP_NOP;
      model(c, v);
      verify(c);
   endtask

   initial begin
      alu_op_e ops [11] = '{OP_ADD, OP_ADDC, OP_SUBB, OP_AND, OP_OR, OP_XOR,
                            OP_CPL, OP_INC, OP_DEC, OP_MUL, OP_DIV};
      int bvals [6] = '{0, 1, 15, 127, 128, 255};
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 acc", int'(acc_q), 0);
      chk("R1 breg", int'(breg_q), 0);
      chk("R1 psw", int'(psw_q), 0);
      chk("R1 zero", int'(acc_is_zero), 1);
      rst_n = 1'b1;
      @(negedge clk);
      step(OP_NOP, 0);
      for (int a = 0; a < 256; a++) begin
         for (int bi = 0; bi < 6; bi++) begin
            for (int c = 0; c < 2; c++) begin
               foreach (ops[k]) begin
                  step(OP_LDA, a);
                  if (ops[k] == OP_MUL || ops[k] == OP_DIV) step(OP_LDB, bvals[bi]);
                  step((c != 0) ? OP_SETC : OP_CLRC, 0);
                  step(ops[k], bvals[bi]);
               end
               // R12: idle cycle with a live operand must change nothing
               step(OP_NOP, 8'hA5);
            end
         end
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule